// File: doc/BRIEF.md
# FM Bit-Timing Recovery Loop

This block recovers bit timing from a bi-phase (FM) coded serial receive stream. It runs from a reference clock at sixteen times the bit rate and keeps a free-running 5-bit phase counter. One trip of the counter, 0 through 31, spans two bit cells. From the counter it issues two strobes, each one reference cycle wide. The receive strobe falls at the quarter and three-quarter points of every cell, so data can be sampled mid-half. The transmit strobe falls on the cell edges, so that transmit cells line up with receive cells. The two strobes are therefore deliberately out of phase.

The receive input passes through a two-stage synchronizer. It is sampled on both the rising and the falling edge of the reference clock, which tells the loop in which half of a count an input transition happened. A transition close to the expected cell boundary, in the middle of the counter trip, moves the counter. If it falls slightly before the boundary, the current trip is shortened by one count. If it falls slightly after, the trip is stretched by one count. A transition in the dead zone right at the boundary leaves the counter alone. Transitions elsewhere in the trip, such as mid-cell data transitions and the other cell boundary, are ignored. At most one correction is taken per trip, and it is applied at the end of the trip, so no strobe is ever dropped or doubled.

A debug bus shows the live counter value and the correction applied in the most recently completed trip.

Top module: `fm_clk_recovery`

## Requirements
- R1: While reset is asserted, the counter reads 0, both strobes are low and the correction code reads 00.
- R2: While enable is low, the counter is held at 0 and neither strobe pulses. Receive transitions seen while disabled have no effect on the first trip after enable returns: that trip is 32 cycles long and ends with correction code 00.
- R3: With no receive transitions, the counter steps by one each reference cycle, from 0 to 31, and wraps to 0, giving a 32-cycle trip.
- R4: The receive strobe is high for exactly the cycles in which the counter reads 4, 12, 20 or 28. The transmit strobe is high for exactly the cycles in which it reads 0, 8, 16 or 24. The two strobes are never high together.
- R5: A transition in the second half of count 15 or in the first half of count 16 causes no correction. The trip lasts 32 cycles and the correction code at the next 0 is 00.
- R6: A transition from the second half of count 16 through the end of count 19 stretches the trip to 33 cycles. The counter reads 31 for two cycles, and the correction code at the next 0 is 01.
- R7: A transition from the start of count 12 through the first half of count 15 shortens the trip to 31 cycles. The counter goes from 30 straight to 0, and the correction code at the next 0 is 10.
- R8: Transitions during counts 20 through 31 and counts 0 through 11 are ignored. The trip stays 32 cycles with correction code 00.
- R9: Only the first qualifying transition in a trip takes effect. A later early or late transition in the same trip does not change the trip length a second time.
- R10: A bi-phase stream whose transitions jitter by up to two counts, starting three counts off phase, is pulled in. Thereafter every receive strobe lies within one count of the quarter or three-quarter point of a nominal cell, and every transmit strobe lies within one count of a cell edge or the cell middle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_16x | input | 1 | Reference clock at sixteen times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the counter at 0 and blocks the strobes |
| rxd | input | 1 | Raw bi-phase receive data, asynchronous |
| rx_clk | output | 1 | Receive sampling strobe, one reference cycle wide |
| tx_clk | output | 1 | Transmit cell strobe, one reference cycle wide |
| dbg_cnt | output | 5 | Current phase counter value |
| dbg_corr | output | 2 | Correction of the last finished trip: 00 none, 01 stretched, 10 shortened |

## Verification
The bench places single transitions in both halves of counts 12, 15, 16, 17 and 19, and times each trip. A loop that resolves only whole counts would show up as a wrong trip length at the second half of 15 or the first half of 16. A loop with the window bounds off by one would stretch or shorten where it should not. Pairs of qualifying transitions in one trip catch a design that corrects twice, which gives 30- or 34-cycle trips. Transitions in the ignored span catch a design that reacts to mid-cell data. A long jittered stream checks that the strobes settle and then stay within one count of the nominal grid, which a loop that applies corrections in the wrong direction or drops strobes at a correction cannot do.

// File: rtl/fm_rec_pkg.sv
package fm_rec_pkg;

  // Correction code; the values are visible on the debug bus.
  typedef enum logic [1:0] {
    CORR_NONE  = 2'b00,
    CORR_LATE  = 2'b01,
    CORR_EARLY = 2'b10
  } corr_e;

endpackage

// File: rtl/fm_rec_edge.sv
// Dual-edge sampler with synchronizer: reports a transition in the first or
// second half of the reference cycle that lies SYNC_STAGES cycles back.
module fm_rec_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic edge_first,
  output logic edge_second
);

  logic                   n_cap_q;
  logic [SYNC_STAGES-1:0] p_sync_q;
  logic [SYNC_STAGES-1:0] n_sync_q;
  logic                   p_old_q;

  // Falling-edge capture gives the mid-cycle sample.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n_cap_q <= 1'b0;
    else        n_cap_q <= rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sync_q <= '0;
      n_sync_q <= '0;
      p_old_q  <= 1'b0;
    end else begin
      p_sync_q <= {p_sync_q[SYNC_STAGES-2:0], rxd};
      n_sync_q <= {n_sync_q[SYNC_STAGES-2:0], n_cap_q};
      p_old_q  <= p_sync_q[SYNC_STAGES-1];
    end
  end

  // Oldest samples in time order: p_old, n_sync[top], p_sync[top].
  assign edge_first  = p_old_q ^ n_sync_q[SYNC_STAGES-1];
  assign edge_second = n_sync_q[SYNC_STAGES-1] ^ p_sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/fm_rec_region.sv
// Maps a detected transition to a correction by its half-count phase.
module fm_rec_region
  import fm_rec_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int WIN   = 4
) (
  input  logic             edge_first,
  input  logic             edge_second,
  input  logic [CNT_W-1:0] cnt_lag,
  output corr_e            dir
);

  localparam int HW = CNT_W + 1;
  // Half-count index of the nominal boundary (start of the middle count).
  localparam logic [HW-1:0] H_BND   = HW'(2 ** CNT_W);
  localparam logic [HW-1:0] H_E_LO  = H_BND - HW'(2 * WIN);
  localparam logic [HW-1:0] H_E_HI  = H_BND - HW'(2);
  localparam logic [HW-1:0] H_L_LO  = H_BND + HW'(1);
  localparam logic [HW-1:0] H_L_HI  = H_BND + HW'(2 * WIN - 1);

  function automatic corr_e classify(input logic [HW-1:0] h);
    if (h >= H_E_LO && h <= H_E_HI)      return CORR_EARLY;
    else if (h >= H_L_LO && h <= H_L_HI) return CORR_LATE;
    else                                  return CORR_NONE;
  endfunction

  always_comb begin
    dir = CORR_NONE;
    if (edge_first)       dir = classify({cnt_lag, 1'b0});
    else if (edge_second) dir = classify({cnt_lag, 1'b1});
  end

endmodule

// File: rtl/fm_rec_count.sv
// Phase counter, correction bookkeeping at trip end, strobe generation.
module fm_rec_count
  import fm_rec_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  corr_e            dir,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_lag,
  output logic             rx_q,
  output logic             tx_q,
  output corr_e            last_q
);

  localparam int              STEP_W   = CNT_W - 2;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_LAST - 1'b1;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [STEP_W-1:0] RX_OFS  = {1'b1, {(STEP_W-1){1'b0}}};

  corr_e            pend_q, pend_n, last_n;
  logic             done_q, done_n, held_q, held_n, rx_n, tx_n;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] lag_q [SYNC_STAGES];

  always_comb begin
    cnt_n  = cnt_q;
    pend_n = pend_q;
    done_n = done_q;
    held_n = held_q;
    last_n = last_q;
    if (!en) begin
      cnt_n  = '0;
      pend_n = CORR_NONE;
      done_n = 1'b0;
      held_n = 1'b0;
    end else begin
      if (dir != CORR_NONE && !done_q) begin
        pend_n = dir;
        done_n = 1'b1;
      end
      if (cnt_q == CNT_LAST && pend_q == CORR_LATE && !held_q) begin
        held_n = 1'b1;                  // stretch: repeat the last count
      end else if ((cnt_q == CNT_PRE && pend_q == CORR_EARLY) ||
                   cnt_q == CNT_LAST) begin
        cnt_n  = '0;                    // wrap, possibly skipping the last count
        last_n = pend_q;
        pend_n = CORR_NONE;
        done_n = 1'b0;
        held_n = 1'b0;
      end else begin
        cnt_n = cnt_q + CNT_ONE;
      end
    end
    rx_n = en && (cnt_n[STEP_W-1:0] == RX_OFS);
    tx_n = en && (cnt_n[STEP_W-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= CORR_NONE;
      done_q <= 1'b0;
      held_q <= 1'b0;
      last_q <= CORR_NONE;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      done_q <= done_n;
      held_q <= held_n;
      last_q <= last_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
    end
  end

  // Delay line aligning the counter with the synchronizer latency.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_lag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lag_q[g] <= '0;
      else if (g == 0) lag_q[g] <= cnt_q;
      else             lag_q[g] <= lag_q[(g == 0) ? 0 : g-1];
    end
  end
  assign cnt_lag = lag_q[SYNC_STAGES-1];

  // R2: disabled loop parks at zero with quiet strobes
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !rx_q && !tx_q));

  // R3: plain increment away from the trip end
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q < CNT_PRE) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6: the last count is repeated at most once
  a_r6_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == CNT_LAST && $past(cnt_q) == CNT_LAST) |=> (cnt_q == '0));

  // R9: a taken correction is not replaced within its trip
  a_r9_pend_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend_q != CORR_NONE && cnt_q < CNT_PRE) |=> (pend_q == $past(pend_q)));

endmodule

// File: rtl/fm_clk_recovery.sv
module fm_clk_recovery
  import fm_rec_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int WIN         = 4
) (
  input  logic             clk_16x,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rxd,
  output logic             rx_clk,
  output logic             tx_clk,
  output logic [CNT_W-1:0] dbg_cnt,
  output logic [1:0]       dbg_corr
);

  logic             edge_first, edge_second;
  logic [CNT_W-1:0] cnt_lag;
  corr_e            dir, last_corr;

  fm_rec_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk_16x), .rst_n(rst_n), .rxd(rxd),
    .edge_first(edge_first), .edge_second(edge_second)
  );

  fm_rec_region #(.CNT_W(CNT_W), .WIN(WIN)) u_region (
    .edge_first(edge_first), .edge_second(edge_second),
    .cnt_lag(cnt_lag), .dir(dir)
  );

  fm_rec_count #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_count (
    .clk(clk_16x), .rst_n(rst_n), .en(en), .dir(dir),
    .cnt_q(dbg_cnt), .cnt_lag(cnt_lag),
    .rx_q(rx_clk), .tx_q(tx_clk), .last_q(last_corr)
  );

  assign dbg_corr = last_corr;

  // R4: receive and transmit strobes never coincide
  a_r4_strobe_sep: assert property (@(posedge clk_16x) disable iff (!rst_n)
    rx_clk |-> !tx_clk);

endmodule

// File: tb/fm_clk_recovery_tb_top.sv
module fm_clk_recovery_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       rxd;
  logic       rx_clk, tx_clk;
  logic [4:0] dbg_cnt;
  logic [1:0] dbg_corr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_clk_recovery dut_i (
    .clk_16x(clk), .rst_n(rst_n), .en(en), .rxd(rxd),
    .rx_clk(rx_clk), .tx_clk(tx_clk), .dbg_cnt(dbg_cnt), .dbg_corr(dbg_corr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance to 1 time unit after the next rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_cnt(input int v);
    for (int g = 0; g < 100 && dbg_cnt != v[4:0]; g++) tick();
  endtask

  // Toggle rxd in the first (half=0) or second (half=1) half of this cycle.
  task automatic toggle_at(input int half);
    if (half == 0) #2;
    else           #7;
    rxd = ~rxd;
  endtask

  // Time one trip; inject up to two transitions at given counts/halves.
  task automatic run_trip(input int c1, input int h1, input int c2, input int h2,
                          input int exp_len, input int exp_corr, input string req);
    int n = 0;
    bit d1 = 0, d2 = 0;
    wait_cnt(0);
    do begin
      tick();
      n++;
      if (!d1 && c1 >= 0 && dbg_cnt == c1[4:0]) begin
        d1 = 1;
        toggle_at(h1);
      end else if (!d2 && c2 >= 0 && dbg_cnt == c2[4:0]) begin
        d2 = 1;
        toggle_at(h2);
      end
    end while (dbg_cnt != 0 && n < 40);
    check(n == exp_len, {req, " trip length"}, n, exp_len);
    check(dbg_corr == exp_corr[1:0], {req, " correction code"}, dbg_corr, exp_corr);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; en = 1'b1; rxd = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(dbg_cnt == 0, "R1 counter in reset", dbg_cnt, 0);
      check(!rx_clk && !tx_clk, "R1 strobes in reset", {rx_clk, tx_clk}, 0);
      check(dbg_corr == 2'b00, "R1 correction in reset", dbg_corr, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic test_free_run();
    int prev;
    wait_cnt(0);
    prev = 0;
    for (int i = 0; i < 64; i++) begin
      tick();
      check(dbg_cnt == (prev + 1) % 32, "R3 counter step", dbg_cnt, (prev + 1) % 32);
      check(rx_clk == (dbg_cnt % 8 == 4), "R4 receive strobe", rx_clk, dbg_cnt % 8 == 4);
      check(tx_clk == (dbg_cnt % 8 == 0), "R4 transmit strobe", tx_clk, dbg_cnt % 8 == 0);
      prev = dbg_cnt;
    end
  endtask

  task automatic test_dead_zone();
    run_trip(15, 1, -1, 0, 32, 0, "R5 late half of 15");
    run_trip(16, 0, -1, 0, 32, 0, "R5 early half of 16");
  endtask

  task automatic test_late();
    run_trip(16, 1, -1, 0, 33, 1, "R6 late half of 16");
    run_trip(17, 0, -1, 0, 33, 1, "R6 count 17");
    run_trip(19, 1, -1, 0, 33, 1, "R6 late half of 19");
  endtask

  task automatic test_early();
    run_trip(12, 0, -1, 0, 31, 2, "R7 early half of 12");
    run_trip(13, 1, -1, 0, 31, 2, "R7 count 13");
    run_trip(15, 0, -1, 0, 31, 2, "R7 early half of 15");
  endtask

  task automatic test_ignored();
    run_trip(8, 0, 25, 1, 32, 0, "R8 counts 8 and 25");
    run_trip(11, 1, 20, 0, 32, 0, "R8 counts 11 and 20");
  endtask

  task automatic test_single();
    run_trip(13, 0, 18, 1, 31, 2, "R9 early then late");
    run_trip(16, 1, 19, 0, 33, 1, "R9 late then late");
  endtask

  task automatic test_disable();
    wait_cnt(5);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      check(dbg_cnt == 0, "R2 counter held", dbg_cnt, 0);
      check(!rx_clk && !tx_clk, "R2 strobes quiet", {rx_clk, tx_clk}, 0);
      if (i == 6 || i == 12) toggle_at(i % 2);
    end
    en = 1'b1;
    run_trip(-1, 0, -1, 0, 32, 0, "R2 first trip after enable");
  endtask

  function automatic int jit(input int k);
    int pat[7] = '{2, -2, 1, -1, 0, -2, 2};
    if (k < 10) return 0;
    return pat[((k - 10) / 2) % 7];
  endfunction

  task automatic test_lock();
    localparam int BASE   = 35;   // first boundary, 3 counts behind count 16
    localparam int SETTLE = 10;
    localparam int CELLS  = 80;
    int k = 0, next_b = BASE, next_m = -1, n_ok = 0, off;
    wait_cnt(16);
    for (int i = 1; i < BASE + 16 * CELLS; i++) begin
      tick();
      if (i >= BASE + 16 * SETTLE) begin
        off = (i - BASE) % 16;
        if (rx_clk) begin
          check(off inside {3, 4, 5, 11, 12, 13}, "R10 receive strobe phase", off, 4);
          n_ok++;
        end
        if (tx_clk) begin
          check(off inside {15, 0, 1, 7, 8, 9}, "R10 transmit strobe phase", off, 0);
          n_ok++;
        end
      end
      if (i == next_b) begin
        next_m = (k % 3 == 1) ? BASE + 16 * k + 8 : -1;
        k++;
        next_b = BASE + 16 * k + jit(k);
        toggle_at(0);
      end else if (i == next_m) begin
        toggle_at(0);
      end
    end
    check(n_ok > 200, "R10 strobes observed after settling", n_ok, 200);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_free_run();
    test_dead_zone();
    test_late();
    test_early();
    test_ignored();
    test_single();
    test_disable();
    test_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule